// File: doc/BRIEF.md
# SMBus Timeout and Clock-Extend Monitor

This block watches the two wires of an SMBus segment and the local controller's own clock-stretching activity, and reports a timeout violation when a programmed duration is exceeded. Time is measured in units of an external prescaled tick pulse, so the same 12-bit limits serve any system clock.

Two independent limits are checked. The first limit has two uses, selected by a mode input: it can time a continuous low period on the clock line, or a continuous period in which both lines are high (bus-idle detection). The second limit accumulates the ticks during which the local device, in its current role, is holding the clock low. It keeps counting across byte boundaries and starts again only at a START or STOP condition. On any violation the block raises a sticky flag that software clears with a strobe, drives an interrupt when enabled, and sends a one-cycle recovery request to the bit-level protocol engine: generate a STOP when the device is the master, or let go of both lines when it is a slave.

The block assumes `tick` is a single-cycle pulse and that the line and extend inputs are already synchronous to `clk`.

Top module: `smbus_timeout_monitor`

## Requirements
- R1: With `idleMode`=0 and `enA`=1, a violation is detected on the tick at which the number of consecutive ticks seen with `sclIn`=0, this one included, reaches `limitA`; any cycle with `sclIn`=1 returns that count to zero.
- R2: With `idleMode`=1 and `enA`=1, the same counting applies to the condition `sclIn`=1 and `sdaIn`=1; a cycle in which either line is low returns the count to zero.
- R3: Counts advance only in cycles where `tick`=1; a held condition without ticks never causes a violation.
- R4: With `enB`=1, a violation is detected on the tick at which the number of ticks seen while the role-selected extend input is 1 (`masterExtend` if `isMaster`=1, else `slaveExtend`), this one included, reaches `limitB`. Ticks without extension leave this total unchanged; a `busStart` or `busStop` strobe returns it to zero and that cycle's tick is not counted.
- R5: A limit whose enable (`enA`, `enB`) is 0 never causes a violation. A limit value of 0 or 1 with its enable set causes a violation on the first qualifying tick.
- R6: On the clock edge that samples a violating tick, `stopReq` pulses high for one cycle if `isMaster`=1, otherwise `releaseReq` does; the two are never high together.
- R7: `timeoutFlag` is 0 after reset, goes to 1 on the edge that samples a violation, and stays 1 until a cycle with `flagClr`=1 and no violation; a violation in the same cycle as `flagClr` leaves it at 1.
- R8: `irq` equals `timeoutFlag` AND `irqEn` at all times.
- R9: After a violation the count of the limit that fired restarts from zero, so a persisting condition fires again only after another full limit of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time-base pulse |
| sclIn | input | 1 | Synchronized clock-line level |
| sdaIn | input | 1 | Synchronized data-line level |
| busStart | input | 1 | START condition detected (one cycle) |
| busStop | input | 1 | STOP condition detected (one cycle) |
| isMaster | input | 1 | 1 = local device is master, 0 = slave |
| masterExtend | input | 1 | Local master is holding the clock low |
| slaveExtend | input | 1 | Local slave is holding the clock low |
| idleMode | input | 1 | 0 = limit A times clock low, 1 = limit A times bus idle |
| enA | input | 1 | Enable for limit A |
| enB | input | 1 | Enable for limit B |
| limitA | input | 12 | Limit A in ticks |
| limitB | input | 12 | Limit B in ticks |
| irqEn | input | 1 | Error interrupt enable |
| flagClr | input | 1 | Clear strobe for the timeout flag |
| timeoutFlag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Error interrupt |
| stopReq | output | 1 | One-cycle request to generate STOP (master) |
| releaseReq | output | 1 | One-cycle request to release both lines (slave) |

## Verification
A counter that fails to clear when the condition breaks, or counts without a tick, shows as a recovery pulse and flag rise on the wrong tick, at most one limit period after the fault, so the bench compares every output against a tick-accurate model on each cycle. A miscounted cumulative total appears only after the extend pattern is interrupted by non-extending ticks or a START strobe, so those patterns are driven explicitly. A flag or role decode error is visible in the cycle right after the violating tick.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  localparam int LIMIT_W = 12;
  localparam int NUM_LIM = 2;

  typedef struct packed {
    logic [NUM_LIM-1:0] clr;
    logic [NUM_LIM-1:0] inc;
  } ctrlStrobes_t;
endpackage

// File: rtl/smbto_datapath.sv
module smbto_datapath
  import smbto_pkg::*;
#(
  parameter int LW = LIMIT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [LW-1:0]        limitA,
  input  logic [LW-1:0]        limitB,
  output logic [NUM_LIM-1:0]   reach
);
  localparam int EW = LW + 1;

  logic [NUM_LIM-1:0][LW-1:0] limits;
  assign limits[0] = limitA;
  assign limits[1] = limitB;

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_cnt
    logic [LW-1:0] count;
    logic [EW-1:0] nextCount;

    assign nextCount = {1'b0, count} + EW'(1);
    // Reached when this tick would bring the total to the limit.
    assign reach[g] = nextCount >= {1'b0, limits[g]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        count <= '0;
      end else if (strobes.clr[g]) begin
        count <= '0;
      end else if (strobes.inc[g]) begin
        count <= nextCount[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/smbto_control.sv
module smbto_control
  import smbto_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               busStart,
  input  logic               busStop,
  input  logic               isMaster,
  input  logic               masterExtend,
  input  logic               slaveExtend,
  input  logic               idleMode,
  input  logic               enA,
  input  logic               enB,
  input  logic               irqEn,
  input  logic               flagClr,
  input  logic [NUM_LIM-1:0] reach,
  output ctrlStrobes_t       strobes,
  output logic               timeoutFlag,
  output logic               irq,
  output logic               stopReq,
  output logic               releaseReq
);
  logic condA;
  logic extendNow;
  logic framing;
  logic hitA;
  logic hitB;
  logic anyHit;
  logic flagQ;
  logic stopQ;
  logic relQ;

  assign condA     = idleMode ? (sclIn & sdaIn) : ~sclIn;
  assign extendNow = isMaster ? masterExtend : slaveExtend;
  assign framing   = busStart | busStop;

  assign hitA   = enA & condA & tick & reach[0];
  assign hitB   = enB & ~framing & extendNow & tick & reach[1];
  assign anyHit = hitA | hitB;

  always_comb begin
    strobes = '0;
    strobes.clr[0] = ~enA | ~condA | hitA;
    strobes.inc[0] = tick & ~reach[0];
    strobes.clr[1] = ~enB | framing | hitB;
    strobes.inc[1] = tick & extendNow & ~reach[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      stopQ <= 1'b0;
      relQ  <= 1'b0;
    end else begin
      stopQ <= anyHit & isMaster;
      relQ  <= anyHit & ~isMaster;
      if (anyHit) begin
        flagQ <= 1'b1;
      end else if (flagClr) begin
        flagQ <= 1'b0;
      end
    end
  end

  assign timeoutFlag = flagQ;
  assign irq         = flagQ & irqEn;
  assign stopReq     = stopQ;
  assign releaseReq  = relQ;
endmodule

// File: rtl/smbus_timeout_monitor.sv
module smbus_timeout_monitor
  import smbto_pkg::*;
#(
  parameter int LW = LIMIT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          busStart,
  input  logic          busStop,
  input  logic          isMaster,
  input  logic          masterExtend,
  input  logic          slaveExtend,
  input  logic          idleMode,
  input  logic          enA,
  input  logic          enB,
  input  logic [LW-1:0] limitA,
  input  logic [LW-1:0] limitB,
  input  logic          irqEn,
  input  logic          flagClr,
  output logic          timeoutFlag,
  output logic          irq,
  output logic          stopReq,
  output logic          releaseReq
);
  ctrlStrobes_t       strobes;
  logic [NUM_LIM-1:0] reach;

  smbto_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .busStart     (busStart),
    .busStop      (busStop),
    .isMaster     (isMaster),
    .masterExtend (masterExtend),
    .slaveExtend  (slaveExtend),
    .idleMode     (idleMode),
    .enA          (enA),
    .enB          (enB),
    .irqEn        (irqEn),
    .flagClr      (flagClr),
    .reach        (reach),
    .strobes      (strobes),
    .timeoutFlag  (timeoutFlag),
    .irq          (irq),
    .stopReq      (stopReq),
    .releaseReq   (releaseReq)
  );

  smbto_datapath #(.LW(LW)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .limitA  (limitA),
    .limitB  (limitB),
    .reach   (reach)
  );
endmodule

// File: rtl/smbto_checker.sv
module smbto_checker (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic isMaster,
  input logic enA,
  input logic enB,
  input logic irqEn,
  input logic flagClr,
  input logic timeoutFlag,
  input logic irq,
  input logic stopReq,
  input logic releaseReq
);
  assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !(stopReq || releaseReq));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!enA && !enB) |=> !(stopReq || releaseReq));

  assert_one_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> !releaseReq);

  assert_stop_master_R6: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> $past(isMaster));

  assert_release_slave_R6: assert property (@(posedge clk) disable iff (!rstN)
    releaseReq |-> !$past(isMaster));

  assert_rise_has_request_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (stopReq || releaseReq));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !flagClr) |=> timeoutFlag);

  assert_request_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq || releaseReq) |-> timeoutFlag);

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEn && timeoutFlag));
endmodule

bind smbus_timeout_monitor smbto_checker u_smbtoChecker (
  .clk         (clk),
  .rstN        (rstN),
  .tick        (tick),
  .isMaster    (isMaster),
  .enA         (enA),
  .enB         (enB),
  .irqEn       (irqEn),
  .flagClr     (flagClr),
  .timeoutFlag (timeoutFlag),
  .irq         (irq),
  .stopReq     (stopReq),
  .releaseReq  (releaseReq)
);

// File: tb/test_smbus_timeout_monitor.sv
`timescale 1ns/1ps
module test_smbus_timeout_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 0, sclIn = 1, sdaIn = 1, busStart = 0, busStop = 0;
  logic isMaster = 1, masterExtend = 0, slaveExtend = 0, idleMode = 0;
  logic enA = 0, enB = 0, irqEn = 0, flagClr = 0;
  logic [11:0] limitA = 12'd5, limitB = 12'd6;
  logic timeoutFlag, irq, stopReq, releaseReq;

  int checks = 0;
  int fails = 0;
  bit cmpOn = 0;
  bit done = 0;

  // reference model state
  int mCntA = 0, mCntB = 0;
  bit mFlag = 0, mStop = 0, mRel = 0;

  always #2 clk = ~clk;

  smbus_timeout_monitor i_smbus_timeout_monitor (
    .clk(clk), .rstN(rstN), .tick(tick), .sclIn(sclIn), .sdaIn(sdaIn),
    .busStart(busStart), .busStop(busStop), .isMaster(isMaster),
    .masterExtend(masterExtend), .slaveExtend(slaveExtend),
    .idleMode(idleMode), .enA(enA), .enB(enB), .limitA(limitA),
    .limitB(limitB), .irqEn(irqEn), .flagClr(flagClr),
    .timeoutFlag(timeoutFlag), .irq(irq), .stopReq(stopReq),
    .releaseReq(releaseReq)
  );

  always @(posedge clk) begin
    bit cond, ext, hit;
    if (!rstN) begin
      mCntA = 0; mCntB = 0; mFlag = 0; mStop = 0; mRel = 0;
    end else begin
      hit = 0;
      cond = idleMode ? (sclIn && sdaIn) : !sclIn;
      if (!enA || !cond) mCntA = 0;
      else if (tick) begin
        if (mCntA + 1 >= int'(limitA)) begin hit = 1; mCntA = 0; end
        else mCntA++;
      end
      ext = isMaster ? masterExtend : slaveExtend;
      if (!enB || busStart || busStop) mCntB = 0;
      else if (tick && ext) begin
        if (mCntB + 1 >= int'(limitB)) begin hit = 1; mCntB = 0; end
        else mCntB++;
      end
      mStop = hit && isMaster;
      mRel  = hit && !isMaster;
      if (hit) mFlag = 1;
      else if (flagClr) mFlag = 0;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      check("R7 timeoutFlag vs model", timeoutFlag, mFlag);
      check("R8 irq vs model", irq, mFlag && irqEn);
      check("R6 stopReq vs model", stopReq, mStop);
      check("R6 releaseReq vs model", releaseReq, mRel);
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(); tick = 0; cyc(2);
    end
  endtask

  task automatic clearFlag();
    flagClr = 1; cyc(); flagClr = 0; cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rstN = 1;
    cyc();
    cmpOn = 1;
    check("R7 reset flag", timeoutFlag, 1'b0);
    check("R6 reset stopReq", stopReq, 1'b0);

    // R1: clock-low timeout, master role, limit 5
    irqEn = 1; enA = 1; isMaster = 1; sclIn = 0;
    ticks(4);
    check("R1 no timeout after 4 ticks", timeoutFlag, 1'b0);
    ticks(1);
    check("R1 timeout on 5th tick", timeoutFlag, 1'b1);
    clearFlag();
    // R9: restart after violation
    ticks(4);
    check("R9 restarted count below limit", timeoutFlag, 1'b0);
    ticks(1);
    check("R9 second violation after full limit", timeoutFlag, 1'b1);
    sclIn = 1; cyc(); clearFlag();
    // R1: condition broken mid-count
    sclIn = 0; ticks(3); sclIn = 1; cyc(); sclIn = 0; ticks(4);
    check("R1 count restarts when SCL high", timeoutFlag, 1'b0);
    ticks(1);
    check("R1 fires after fresh 5 ticks", timeoutFlag, 1'b1);
    // R3: no ticks, no violation
    sclIn = 1; cyc(); clearFlag(); sclIn = 0;
    cyc(40);
    check("R3 held low without ticks", timeoutFlag, 1'b0);
    sclIn = 1; cyc();

    // R2: idle detect, slave role
    idleMode = 1; isMaster = 0; limitA = 12'd3; sdaIn = 0;
    ticks(6);
    check("R2 SDA low blocks idle count", timeoutFlag, 1'b0);
    sdaIn = 1; ticks(2);
    check("R2 idle below limit", timeoutFlag, 1'b0);
    ticks(1);
    check("R2 idle timeout", timeoutFlag, 1'b1);
    irqEn = 0; cyc(2); clearFlag(); irqEn = 1;

    // R4: cumulative extend, master role
    enA = 0; idleMode = 0; enB = 1; isMaster = 1; limitB = 12'd6;
    masterExtend = 1; ticks(3);
    masterExtend = 0; ticks(2);
    masterExtend = 1; ticks(2);
    check("R4 5 extend ticks below limit", timeoutFlag, 1'b0);
    ticks(1);
    check("R4 cumulative extend reaches limit", timeoutFlag, 1'b1);
    clearFlag();
    masterExtend = 0; slaveExtend = 1; ticks(8);
    check("R4 slave extend ignored in master role", timeoutFlag, 1'b0);
    slaveExtend = 0; masterExtend = 1; ticks(4);
    busStart = 1; tick = 1; cyc(); busStart = 0; tick = 0; cyc(2);
    ticks(4);
    check("R4 START clears cumulative total", timeoutFlag, 1'b0);
    busStop = 1; cyc(); busStop = 0;
    // R5: disabled limit B
    enB = 0; ticks(10);
    check("R5 disabled limit B", timeoutFlag, 1'b0);
    // R5: zero limit fires on first tick, slave role
    isMaster = 0; masterExtend = 0; slaveExtend = 1; enB = 1; limitB = 12'd0;
    ticks(1);
    check("R5 zero limit first tick", timeoutFlag, 1'b1);
    // R7: clear strobe coinciding with violation keeps flag
    flagClr = 1; tick = 1; cyc(); flagClr = 0; tick = 0; cyc();
    check("R7 set wins over clear", timeoutFlag, 1'b1);
    slaveExtend = 0; enB = 0; cyc();
    clearFlag();
    check("R7 clear strobe clears flag", timeoutFlag, 1'b0);
    irqEn = 0; cyc(2);
    check("R8 irq low when flag low", irq, 1'b0);

    cyc(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule